// File: doc/BRIEF.md
# Strobe-Driven DRAM Device Control Front-End

This block sits where a single asynchronous DRAM die would sit and interprets the row strobe, column strobe, write enable and output enable as such a die does. Every strobe is oversampled by a fast internal clock through a synchroniser chain. The block judges which edge came first only from the sampled edges. From that ordering it classifies each access as a read, an early write, a late write, a row-only refresh or a refresh in which the column strobe comes before the row strobe. Each classification produces a one-cycle array command: activate, column read, column write or precharge.

The row address is latched when the row strobe falls. While the row stays open, every further column-strobe fall latches a new column in that row (page mode). A refresh with the column strobe leading takes its row from an internal counter, which then advances and wraps around. A small register array stands in for the cell array and is indexed by the low address bits.

The block keeps a saturating age counter for every row. Any row activation clears the counter of that row. A sticky flag rises when any row goes longer than the retention window without being activated.

Top module: `dram_fe_top`

## Requirements
- R1: After reset, `cmd` is 0 (no operation), `cycle_kind` is 0 (idle), `dq_oe` and `ret_err` are low, and the internal refresh counter is 0, so the first column-first refresh opens row 0.
- R2: A fall of `ras_n` while `cas_n` is high issues the activate command (`cmd`=1) for one cycle, with `cmd_row` equal to `addr` and `cycle_kind`=4. With two synchroniser stages, the pulse is visible after the third rising clock edge following the pin change.
- R3: A fall of `cas_n` while the row is open and `we_n` is high issues a column read (`cmd`=2) with `cmd_col` equal to `addr` and `cycle_kind`=1. `dq_out` then shows the stored word, and `dq_oe` is high exactly while that read is live, `cas_n` is low and `oe_n` is low.
- R4: While `ras_n` stays low, each new `cas_n` fall captures a new column, and `cmd_row` keeps the row latched at activation.
- R5: If `we_n` is already low when the `cas_n` fall is sampled, the access is an early write. The block issues `cmd`=3 with `cycle_kind`=2, stores `dq_in` at the open row and the new column, and never drives `dq_oe` during that column cycle.
- R6: If `we_n` falls after `cas_n` has fallen in a read, the access is a late write. The block issues `cmd`=3 with `cycle_kind`=3 at the column latched by the read, stores `dq_in` there and drops `dq_oe`.
- R7: If `cas_n` is already low when `ras_n` falls, the block issues an activate with `cycle_kind`=5 and `cmd_row` taken from the refresh counter. The counter then advances by one and wraps from its top value to 0.
- R8: A rise of `ras_n` after an activation issues precharge (`cmd`=4) and sets `cycle_kind` to 0.
- R9: Toggling `ras_n` while `cas_n` stays low after a read (hidden refresh) performs a column-first refresh and keeps `dq_oe` and `dq_out` unchanged.
- R10: Each row's age counts clock cycles since that row was last activated, by any kind of row cycle. `ret_err` rises one cycle after any age exceeds `RET_LIMIT` and then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data from the bus |
| dq_out | output | DQ_W | Read data toward the bus |
| dq_oe | output | 1 | Drive enable for dq_out |
| cmd | output | 3 | Array command pulse: 0 nop, 1 activate, 2 read, 3 write, 4 precharge |
| cmd_row | output | ADDR_W | Row of the current command |
| cmd_col | output | ADDR_W | Column of a read or write command |
| cycle_kind | output | 3 | 0 idle, 1 read, 2 early write, 3 late write, 4 row-only refresh, 5 column-first refresh |
| ret_err | output | 1 | Sticky retention violation flag |

## Verification
The bench builds the block with a 3-bit address, a 4-bit word and a stand-in array as wide as the address space (8 rows by 8 columns). This lets page-mode early writes followed by reads cover every cell, with two complementary data patterns. A refresh counter of only 8 rows makes the wrap visible within a few column-first refreshes. `RET_LIMIT` is set to 300 cycles, so the bench can check the exact cycle at which the retention flag rises, and can show that a full refresh sweep keeps the flag low.

// File: rtl/dram_fe_pkg.sv
package dram_fe_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4
   } arr_cmd_e;

   typedef enum logic [2:0] {
      KIND_IDLE = 3'd0,
      KIND_READ = 3'd1,
      KIND_EWR  = 3'd2,
      KIND_LWR  = 3'd3,
      KIND_RFSH = 3'd4,
      KIND_CBR  = 3'd5
   } cyc_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ROW  = 2'd1,
      ST_CBR  = 2'd2
   } fe_state_e;

endpackage

// File: rtl/dram_fe_sync.sv
module dram_fe_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dram_fe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/dram_fe_refcnt.sv
module dram_fe_refcnt #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [AW-1:0] cnt
);

   localparam logic [AW-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
   end

   AST_REF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt == TOP) |=> (cnt == '0));  // R7

   AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt));  // R7

endmodule

// File: rtl/dram_fe_age.sv
module dram_fe_age #(
   parameter int AW     = 10,
   parameter int LIMIT  = 3_200_000,
   parameter bit EN     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [AW-1:0] touch_row,
   output logic          ret_err
);

   localparam int NROWS = 1 << AW;
   localparam int CW    = $clog2(LIMIT + 2);
   localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("dram_fe_age: LIMIT must be positive");
      end

      if (EN) begin : g_track
         logic [NROWS-1:0] over;
         logic             err_q;

         for (genvar g = 0; g < NROWS; g++) begin : g_row
            logic [CW-1:0] age;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                           age <= '0;
               else if (touch && touch_row == AW'(g)) age <= '0;
               else if (age != SAT)                  age <= age + 1'b1;
            end
            assign over[g] = (age == SAT);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= err_q | (|over);
         end
         assign ret_err = err_q;

         AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            err_q |=> err_q);  // R10

         AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(err_q) |-> $past(|over));  // R10
      end else begin : g_none
         assign ret_err = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dram_fe_array.sv
module dram_fe_array #(
   parameter int RW = 4,
   parameter int CW = 4,
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [RW-1:0] wr_row,
   input  logic [CW-1:0] wr_col,
   input  logic [DW-1:0] wr_data,
   input  logic [RW-1:0] rd_row,
   input  logic [CW-1:0] rd_col,
   output logic [DW-1:0] rd_data
);

   localparam int NCELL = 1 << (RW + CW);

   logic [DW-1:0] mem [NCELL];

   always_ff @(posedge clk) begin
      if (wr_en) mem[{wr_row, wr_col}] <= wr_data;
   end

   assign rd_data = mem[{rd_row, rd_col}];

endmodule

// File: rtl/dram_fe_top.sv
module dram_fe_top
   import dram_fe_pkg::*;
#(
   parameter int ADDR_W       = 10,
   parameter int DQ_W         = 4,
   parameter int STORE_ROW_W  = 4,
   parameter int STORE_COL_W  = 4,
   parameter int SYNC_STAGES  = 2,
   parameter int RET_LIMIT    = 3_200_000,
   parameter bit RET_CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_in,
   output logic [DQ_W-1:0]   dq_out,
   output logic              dq_oe,
   output logic [2:0]        cmd,
   output logic [ADDR_W-1:0] cmd_row,
   output logic [ADDR_W-1:0] cmd_col,
   output logic [2:0]        cycle_kind,
   output logic              ret_err
);

   localparam int BUS_W = ADDR_W + DQ_W;

   generate
      if (STORE_ROW_W > ADDR_W || STORE_COL_W > ADDR_W) begin : g_bad_store
         $error("dram_fe_top: stand-in array wider than the address");
      end
      if (DQ_W < 1) begin : g_bad_dq
         $error("dram_fe_top: DQ_W must be positive");
      end
   endgenerate

   // ---------------- strobe and bus sampling ----------------
   logic [3:0]        strobe_s;
   logic [BUS_W-1:0]  bus_s;
   logic              s_ras, s_cas, s_we, s_oe;
   logic [ADDR_W-1:0] s_addr;
   logic [DQ_W-1:0]   s_din;

   dram_fe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_sync_strobe (
      .clk(clk), .rst_n(rst_n),
      .d({ras_n, cas_n, we_n, oe_n}), .q(strobe_s)
   );

   dram_fe_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
      .clk(clk), .rst_n(rst_n),
      .d({addr, dq_in}), .q(bus_s)
   );

   assign {s_ras, s_cas, s_we, s_oe} = strobe_s;
   assign {s_addr, s_din}            = bus_s;

   logic ras_p, cas_p, we_p;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_p <= 1'b1;
         cas_p <= 1'b1;
         we_p  <= 1'b1;
      end else begin
         ras_p <= s_ras;
         cas_p <= s_cas;
         we_p  <= s_we;
      end
   end

   logic ras_fall, ras_rise, cas_fall, we_fall;
   assign ras_fall = ras_p  & ~s_ras;
   assign ras_rise = ~ras_p &  s_ras;
   assign cas_fall = cas_p  & ~s_cas;
   assign we_fall  = we_p   & ~s_we;

   // ---------------- cycle classification ----------------
   fe_state_e         st;
   logic [ADDR_W-1:0] row_q, col_q, ref_cnt;
   logic              rd_valid;
   logic              row_live, cbr_sel, act_fire, rd_fire, ewr_fire, lwr_fire;
   logic              wr_fire, pre_fire;
   logic [ADDR_W-1:0] act_row, wr_col;
   logic [DQ_W-1:0]   arr_rd_data;

   assign row_live = (st == ST_ROW) && !s_ras;
   assign act_fire = ras_fall;
   assign cbr_sel  = ras_fall && !cas_p && !s_cas;
   assign act_row  = cbr_sel ? ref_cnt : s_addr;
   assign rd_fire  = row_live && cas_fall &&  s_we;
   assign ewr_fire = row_live && cas_fall && !s_we;
   assign lwr_fire = row_live && rd_valid && !s_cas && we_fall && !cas_fall;
   assign wr_fire  = ewr_fire | lwr_fire;
   assign wr_col   = ewr_fire ? s_addr : col_q;
   assign pre_fire = ras_rise && (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         row_q    <= '0;
         col_q    <= '0;
         rd_valid <= 1'b0;
      end else begin
         if (act_fire)      st <= cbr_sel ? ST_CBR : ST_ROW;
         else if (pre_fire) st <= ST_IDLE;

         if (act_fire) row_q <= act_row;
         if (row_live && cas_fall) col_q <= s_addr;

         if (s_cas)         rd_valid <= 1'b0;
         else if (rd_fire)  rd_valid <= 1'b1;
         else if (lwr_fire) rd_valid <= 1'b0;
      end
   end

   // ---------------- command outputs ----------------
   arr_cmd_e          cmd_q;
   cyc_kind_e         kind_q;
   logic [ADDR_W-1:0] cmd_row_q, cmd_col_q;
   logic [DQ_W-1:0]   dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q     <= CMD_NOP;
         kind_q    <= KIND_IDLE;
         cmd_row_q <= '0;
         cmd_col_q <= '0;
         dout_q    <= '0;
      end else begin
         cmd_q <= CMD_NOP;
         if (act_fire) begin
            cmd_q     <= CMD_ACT;
            kind_q    <= cbr_sel ? KIND_CBR : KIND_RFSH;
            cmd_row_q <= act_row;
         end else if (pre_fire) begin
            cmd_q     <= CMD_PRE;
            kind_q    <= KIND_IDLE;
            cmd_row_q <= row_q;
         end else if (rd_fire) begin
            cmd_q     <= CMD_RD;
            kind_q    <= KIND_READ;
            cmd_row_q <= row_q;
            cmd_col_q <= s_addr;
            dout_q    <= arr_rd_data;
         end else if (wr_fire) begin
            cmd_q     <= CMD_WR;
            kind_q    <= ewr_fire ? KIND_EWR : KIND_LWR;
            cmd_row_q <= row_q;
            cmd_col_q <= wr_col;
         end
      end
   end

   // ---------------- sub-blocks ----------------
   dram_fe_refcnt #(.AW(ADDR_W)) u_refcnt (
      .clk(clk), .rst_n(rst_n), .step(act_fire & cbr_sel), .cnt(ref_cnt)
   );

   dram_fe_age #(.AW(ADDR_W), .LIMIT(RET_LIMIT), .EN(RET_CHECK_EN)) u_age (
      .clk(clk), .rst_n(rst_n), .touch(act_fire), .touch_row(act_row),
      .ret_err(ret_err)
   );

   dram_fe_array #(.RW(STORE_ROW_W), .CW(STORE_COL_W), .DW(DQ_W)) u_array (
      .clk(clk),
      .wr_en(wr_fire),
      .wr_row(row_q[STORE_ROW_W-1:0]),
      .wr_col(wr_col[STORE_COL_W-1:0]),
      .wr_data(s_din),
      .rd_row(row_q[STORE_ROW_W-1:0]),
      .rd_col(s_addr[STORE_COL_W-1:0]),
      .rd_data(arr_rd_data)
   );

   assign cmd        = cmd_q;
   assign cycle_kind = kind_q;
   assign cmd_row    = cmd_row_q;
   assign cmd_col    = cmd_col_q;
   assign dq_out     = dout_q;
   assign dq_oe      = rd_valid & ~s_oe & ~s_cas;

   // ---------------- assertions ----------------
   AST_ACT_ON_ROW_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      ras_fall |=> (cmd_q == CMD_ACT));  // R2

   AST_PRE_ON_ROW_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_rise && st != ST_IDLE) |=> (cmd_q == CMD_PRE));  // R8

   AST_EARLY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == KIND_EWR) |-> !dq_oe);  // R5

   AST_WRITE_STOPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_WR) |-> !dq_oe);  // R6

   AST_CBR_ROW_FROM_COUNTER: assert property (@(posedge clk) disable iff (!rst_n)
      cbr_sel |=> (cmd_row_q == ref_cnt - 1'b1));  // R7

   AST_PAGE_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_RD) |-> (cmd_row_q == row_q));  // R4

endmodule

// File: tb/tb_dram_fe_top.sv
module tb_dram_fe_top;

   localparam int AW  = 3;
   localparam int DW  = 4;
   localparam int LIM = 300;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;
   logic [2:0]    cmd;
   logic [AW-1:0] cmd_row, cmd_col;
   logic [2:0]    cycle_kind;
   logic          ret_err;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;
   logic [DW-1:0] mdl [8][8];
   int ref_exp = 0;

   always #2.5 clk = ~clk;

   dram_fe_top #(
      .ADDR_W(AW), .DQ_W(DW), .STORE_ROW_W(AW), .STORE_COL_W(AW),
      .SYNC_STAGES(2), .RET_LIMIT(LIM), .RET_CHECK_EN(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
      .cmd(cmd), .cmd_row(cmd_row), .cmd_col(cmd_col), .cycle_kind(cycle_kind),
      .ret_err(ret_err)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic drv(input logic r, input logic c, input logic w, input logic o,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; dq_in = d;
   endtask

   // output changes on the third rising edge after a pin change
   task automatic lat();
      repeat (3) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic [DW-1:0] pat(input int r, input int c, input bit inv);
      logic [DW-1:0] v;
      v = DW'((r * 5 + c * 3 + 7) & 15);
      return inv ? ~v : v;
   endfunction

   task automatic cbr_cycle(input string req);
      drv(1, 0, 1, 1, '0, '0); lat();
      drv(0, 0, 1, 1, '0, '0); lat();
      chk(req, "cbr cmd", cmd, 1);
      chk(req, "cbr kind", cycle_kind, 5);
      chk(req, "cbr row", cmd_row, ref_exp);
      ref_exp = (ref_exp + 1) % 8;
      drv(1, 0, 1, 1, '0, '0); lat();
      chk("R8", "pre after cbr", cmd, 4);
      drv(1, 1, 1, 1, '0, '0); lat();
   endtask

   task automatic sweep(input bit inv);
      for (int r = 0; r < 8; r++) begin
         drv(0, 1, 1, 1, AW'(r), '0); lat();
         chk("R2", "act cmd", cmd, 1);
         chk("R2", "act row", cmd_row, r);
         chk("R2", "act kind", cycle_kind, 4);
         for (int c = 0; c < 8; c++) begin
            drv(0, 0, 0, 0, AW'(c), pat(r, c, inv));
            @(negedge clk); chk("R5", "no drive early", dq_oe, 0);
            @(negedge clk); chk("R5", "no drive early", dq_oe, 0);
            @(negedge clk);
            chk("R5", "ewr cmd", cmd, 3);
            chk("R5", "ewr kind", cycle_kind, 2);
            chk("R5", "ewr col", cmd_col, c);
            chk("R5", "no drive early", dq_oe, 0);
            chk("R4", "page row", cmd_row, r);
            mdl[r][c] = pat(r, c, inv);
            drv(0, 1, 1, 0, '0, '0); lat();
         end
         drv(1, 1, 1, 1, '0, '0); lat();
         chk("R8", "pre cmd", cmd, 4);
         chk("R8", "pre kind", cycle_kind, 0);
      end
      for (int r = 0; r < 8; r++) begin
         drv(0, 1, 1, 1, AW'(r), '0); lat();
         for (int c = 0; c < 8; c++) begin
            drv(0, 0, 1, 0, AW'(c), '0); lat();
            chk("R3", "rd cmd", cmd, 2);
            chk("R3", "rd kind", cycle_kind, 1);
            chk("R3", "rd col", cmd_col, c);
            chk("R4", "page row", cmd_row, r);
            chk("R3", "rd oe", dq_oe, 1);
            chk("R3", "rd data", dq_out, mdl[r][c]);
            drv(0, 1, 1, 0, '0, '0); lat();
            chk("R3", "oe off after cas", dq_oe, 0);
         end
         drv(1, 1, 1, 1, '0, '0); lat();
      end
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : main
      // Phase A: reset state and retention timing with no activity
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "cmd", cmd, 0);
      chk("R1", "kind", cycle_kind, 0);
      chk("R1", "dq_oe", dq_oe, 0);
      chk("R1", "ret_err", ret_err, 0);
      repeat (LIM) @(negedge clk);
      chk("R10", "err before limit", ret_err, 0);
      @(negedge clk);
      chk("R10", "err after limit", ret_err, 1);
      repeat (5) @(negedge clk);
      chk("R10", "err sticky", ret_err, 1);

      // Phase B: column-first refresh sweeps, counter wrap, no retention error
      do_reset();
      ref_exp = 0;
      for (int i = 0; i < 24; i++) cbr_cycle((i == 0) ? "R1" : "R7");
      chk("R10", "refreshed rows no err", ret_err, 0);
      drv(0, 1, 1, 1, 3'd5, '0); lat();
      chk("R10", "row-only refresh kind", cycle_kind, 4);
      drv(1, 1, 1, 1, '0, '0); lat();
      chk("R10", "still no err", ret_err, 0);

      // Phase C: exhaustive page-mode writes and reads
      do_reset();
      ref_exp = 0;
      sweep(1'b0);
      sweep(1'b1);

      // late write
      drv(0, 1, 1, 1, 3'd2, '0); lat();
      drv(0, 0, 1, 0, 3'd6, '0); lat();
      chk("R6", "read before late", cmd, 2);
      chk("R6", "oe before late", dq_oe, 1);
      drv(0, 0, 0, 0, 3'd0, 4'h9); lat();
      chk("R6", "lwr cmd", cmd, 3);
      chk("R6", "lwr kind", cycle_kind, 3);
      chk("R6", "lwr col", cmd_col, 6);
      chk("R6", "lwr row", cmd_row, 2);
      chk("R6", "oe dropped", dq_oe, 0);
      drv(0, 1, 1, 0, '0, '0); lat();
      drv(0, 0, 1, 0, 3'd6, '0); lat();
      chk("R6", "late data stored", dq_out, 4'h9);
      drv(0, 1, 1, 0, '0, '0); lat();
      drv(1, 1, 1, 1, '0, '0); lat();

      // output enable gates drive
      drv(0, 1, 1, 1, 3'd4, '0); lat();
      drv(0, 0, 1, 1, 3'd1, '0); lat();
      chk("R3", "oe_n high no drive", dq_oe, 0);
      drv(0, 0, 1, 0, 3'd1, '0); lat();
      chk("R3", "oe_n low drive", dq_oe, 1);
      chk("R3", "data", dq_out, mdl[4][1]);

      // hidden refresh keeps data out
      drv(1, 0, 1, 0, '0, '0); lat();
      chk("R9", "pre cmd", cmd, 4);
      chk("R9", "oe kept on pre", dq_oe, 1);
      drv(0, 0, 1, 0, '0, '0); lat();
      chk("R9", "hidden cbr cmd", cmd, 1);
      chk("R9", "hidden cbr kind", cycle_kind, 5);
      chk("R9", "hidden cbr row", cmd_row, 0);
      chk("R9", "oe kept", dq_oe, 1);
      chk("R9", "data kept", dq_out, mdl[4][1]);
      drv(1, 0, 1, 0, '0, '0); lat();
      drv(1, 1, 1, 1, '0, '0); lat();
      chk("R9", "oe off at end", dq_oe, 0);
      // counter advanced by the hidden refresh
      ref_exp = 1;
      cbr_cycle("R7");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule